// File: doc/BRIEF.md
# Programmable Pixel Color Space Converter

This block converts a stream of three-component 8-bit pixels between the RGB and YCbCr color spaces through a programmable 3x3 matrix with three offset terms. A mode input selects one of three behaviours for each pixel: forward conversion from RGB to YCbCr, inverse conversion from YCbCr to RGB, or a straight pass-through. Every pixel leaves the block a fixed number of cycles after it enters, whatever the mode, so a display pipeline can place the block inline without any flow control.

The offsets are used differently in each conversion mode. In the inverse mode they are added to the incoming components before the matrix multiply, so removing a luma floor of 16 or a chroma midpoint of 128 means programming a negative offset. In the forward mode they are added to the matrix result. Each result is rounded to nearest and clamped into the 0..255 range.

Software loads the nine coefficients and three offsets through a small write port as six 32-bit words. The words land in a shadow copy. The copy used by the datapath takes them over only when no pixel is in flight, so a single pixel is never computed with a mix of old and new values.

Top module: `pix_csc`

## Requirements
- R1: While reset is asserted and after it is released, before any pixel is accepted, `out_valid` is low and all three output components read 0.
- R2: A pixel accepted on a clock edge with `pix_valid` high appears with `out_valid` high after the third rising edge that follows. Acceptance order is kept and every accepted pixel produces exactly one output.
- R3: Mode 2'b00 and mode 2'b11 are pass-through: output components equal the input components unchanged.
- R4: Mode 2'b10 (YCbCr to RGB) computes out[r] = sum over c of M[r][c] * (in[c] + D[c]), with D a signed value that is added.
- R5: Mode 2'b01 (RGB to YCbCr) computes out[r] = sum over c of M[r][c] * in[c] + D[r].
- R6: Coefficients are 11-bit two's complement with 8 fractional bits (0x100 = 1.0). Offsets are 9-bit two's complement whole pixel steps (0x1f0 = -16). Results are rounded by adding one half (0x80 in the scaled domain) and then rounding toward minus infinity.
- R7: Any result below 0 is output as 0, and any result above 255 is output as 255.
- R8: Configuration word k (address 0..5) holds two fields, the first in bits [26:16] (9-bit offsets in [24:16]) and the second in bits [10:0] (offsets in [8:0]). Field order across the words is M00, M01, M02, M10, M11, M12, M20, M21, M22, D0, D1, D2, with M[r][c] meaning row r, column c. Addresses 6 and 7 are ignored.
- R9: Written values take effect only at a clock edge where neither internal pipeline stage holds a pixel and either `pix_valid` is low or `frame_start` is high. A pixel accepted together with `frame_start` on such an edge uses the new values. Pixels accepted before that edge, including those accepted while writes were in progress, use the old values.
- R10: When no new result is produced, the output components hold their previous values regardless of changes at the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address (0..5) |
| cfg_wdata | input | 32 | Configuration word data |
| mode | input | 2 | 00/11 pass-through, 01 RGB to YCbCr, 10 YCbCr to RGB |
| frame_start | input | 1 | Marks the first pixel of a frame; allows pending values to be applied |
| pix_valid | input | 1 | Input pixel valid |
| pix_in_a | input | 8 | Component 0 (R or Y) |
| pix_in_b | input | 8 | Component 1 (G or Cb) |
| pix_in_c | input | 8 | Component 2 (B or Cr) |
| out_valid | output | 1 | Output pixel valid |
| pix_out_a | output | 8 | Result component 0 |
| pix_out_b | output | 8 | Result component 1 |
| pix_out_c | output | 8 | Result component 2 |

## Verification
The main hazard comes when a coefficient write falls in the same cycles as a busy pixel stream. A half-applied coefficient set could corrupt pixels that are already in flight, and a resumed stream could pick up the new values too early. The bench writes a full new matrix while pixels stream back to back and checks that every one of those pixels still matches the old matrix. It then leaves a gap just long enough to empty the pipeline and resumes without `frame_start`, expecting the old matrix again. Finally it resumes after the same gap with `frame_start` on the first pixel and expects the new matrix from exactly that pixel on.

// File: rtl/pix_csc_pkg.sv
package pix_csc_pkg;

  localparam int CSC_PIX_W  = 8;
  localparam int CSC_COEF_W = 11;
  localparam int CSC_OFF_W  = 9;
  localparam int CSC_FRAC_W = 8;
  localparam int CSC_N_CH   = 3;
  localparam int CSC_ADDR_W = 3;
  localparam int CSC_DATA_W = 32;

  typedef enum logic [1:0] {
    CSC_PASS     = 2'b00,
    CSC_RGB2YUV  = 2'b01,
    CSC_YUV2RGB  = 2'b10,
    CSC_PASS_ALT = 2'b11
  } csc_mode_e;

endpackage

// File: rtl/pix_csc_coef_bank.sv
module pix_csc_coef_bank #(
  parameter int N_CH   = 3,
  parameter int COEF_W = 11,
  parameter int OFF_W  = 9,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               commit_ok,
  output logic                               pending,
  output logic [N_CH*N_CH-1:0][COEF_W-1:0]   act_m,
  output logic [N_CH-1:0][OFF_W-1:0]         act_d,
  output logic [N_CH-1:0][OFF_W-1:0]         eff_d
);

  localparam int N_MAT  = N_CH * N_CH;
  localparam int HI_LSB = DATA_W / 2;

  logic [N_MAT-1:0][COEF_W-1:0] sh_m_q, sh_m_d, act_m_q, act_m_d;
  logic [N_CH-1:0][OFF_W-1:0]   sh_d_q, sh_d_d, act_d_q, act_d_d;
  logic                         pend_q, pend_d;
  logic                         commit;

  assign commit = pend_q && commit_ok;

  // Shadow fields: field f lives in word f/2, even f in the high half.
  always_comb begin
    sh_m_d = sh_m_q;
    sh_d_d = sh_d_q;
    for (int k = 0; k < N_MAT; k++) begin
      if (wr_en && (wr_addr == ADDR_W'(k / 2))) begin
        sh_m_d[k] = ((k % 2) == 0) ? wr_data[HI_LSB +: COEF_W]
                                   : wr_data[0 +: COEF_W];
      end
    end
    for (int j = 0; j < N_CH; j++) begin
      if (wr_en && (wr_addr == ADDR_W'((N_MAT + j) / 2))) begin
        sh_d_d[j] = (((N_MAT + j) % 2) == 0) ? wr_data[HI_LSB +: OFF_W]
                                             : wr_data[0 +: OFF_W];
      end
    end
  end

  always_comb begin
    act_m_d = commit ? sh_m_q : act_m_q;
    act_d_d = commit ? sh_d_q : act_d_q;
    if (wr_en) begin
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_m_q  <= '0;
      sh_d_q  <= '0;
      act_m_q <= '0;
      act_d_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      sh_m_q  <= sh_m_d;
      sh_d_q  <= sh_d_d;
      act_m_q <= act_m_d;
      act_d_q <= act_d_d;
      pend_q  <= pend_d;
    end
  end

  assign pending = pend_q;
  assign act_m   = act_m_q;
  assign act_d   = act_d_q;
  // Offsets seen by a pixel entering on the committing edge are the new ones.
  assign eff_d   = commit ? sh_d_q : act_d_q;

endmodule

// File: rtl/pix_csc_offset_stage.sv
module pix_csc_offset_stage
  import pix_csc_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int PIX_W = 8,
  parameter int OFF_W = 9,
  parameter int V_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [1:0]                   in_mode,
  input  logic [N_CH-1:0][PIX_W-1:0]   in_pix,
  input  logic [N_CH-1:0][OFF_W-1:0]   off_d,
  output logic                         s1_valid,
  output logic                         s1_pass,
  output logic [N_CH-1:0][V_W-1:0]     s1_opnd,
  output logic [N_CH-1:0][OFF_W-1:0]   s1_post,
  output logic [N_CH-1:0][PIX_W-1:0]   s1_raw
);

  logic                       vld_q;
  logic                       pass_q, pass_d;
  logic [N_CH-1:0][V_W-1:0]   opnd_q, opnd_d;
  logic [N_CH-1:0][OFF_W-1:0] post_q, post_d;
  logic [N_CH-1:0][PIX_W-1:0] raw_q, raw_d;
  logic                       pre_add, post_add;

  always_comb begin
    pre_add  = (in_mode == CSC_YUV2RGB);
    post_add = (in_mode == CSC_RGB2YUV);
    pass_d   = pass_q;
    opnd_d   = opnd_q;
    post_d   = post_q;
    raw_d    = raw_q;
    if (in_valid) begin
      pass_d = !(pre_add || post_add);
      raw_d  = in_pix;
      for (int c = 0; c < N_CH; c++) begin
        opnd_d[c] = V_W'(in_pix[c]) +
                    (pre_add ? V_W'($signed(off_d[c])) : V_W'(0));
        post_d[c] = post_add ? off_d[c] : OFF_W'(0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
      opnd_q <= '0;
      post_q <= '0;
      raw_q  <= '0;
    end else begin
      vld_q  <= in_valid;
      pass_q <= pass_d;
      opnd_q <= opnd_d;
      post_q <= post_d;
      raw_q  <= raw_d;
    end
  end

  assign s1_valid = vld_q;
  assign s1_pass  = pass_q;
  assign s1_opnd  = opnd_q;
  assign s1_post  = post_q;
  assign s1_raw   = raw_q;

endmodule

// File: rtl/pix_csc_mult_stage.sv
module pix_csc_mult_stage #(
  parameter int N_CH   = 3,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFF_W  = 9,
  parameter int V_W    = 10,
  parameter int PROD_W = 21
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                s1_valid,
  input  logic                                s1_pass,
  input  logic [N_CH-1:0][V_W-1:0]            s1_opnd,
  input  logic [N_CH-1:0][OFF_W-1:0]          s1_post,
  input  logic [N_CH-1:0][PIX_W-1:0]          s1_raw,
  input  logic [N_CH*N_CH-1:0][COEF_W-1:0]    coef,
  output logic                                s2_valid,
  output logic                                s2_pass,
  output logic [N_CH*N_CH-1:0][PROD_W-1:0]    s2_prod,
  output logic [N_CH-1:0][OFF_W-1:0]          s2_post,
  output logic [N_CH-1:0][PIX_W-1:0]          s2_raw
);

  localparam int N_MAT = N_CH * N_CH;

  logic                          vld_q;
  logic                          pass_q, pass_d;
  logic [N_MAT-1:0][PROD_W-1:0]  prod_q, prod_d;
  logic [N_CH-1:0][OFF_W-1:0]    post_q, post_d;
  logic [N_CH-1:0][PIX_W-1:0]    raw_q, raw_d;
  logic [N_MAT-1:0][PROD_W-1:0]  prod_w;

  // One signed multiplier per matrix entry.
  for (genvar r = 0; r < N_CH; r++) begin : g_row
    for (genvar c = 0; c < N_CH; c++) begin : g_col
      logic signed [PROD_W-1:0] mul_s;
      assign mul_s = PROD_W'($signed(coef[r*N_CH+c]) * $signed(s1_opnd[c]));
      assign prod_w[r*N_CH+c] = mul_s;
    end
  end

  always_comb begin
    pass_d = s1_valid ? s1_pass : pass_q;
    prod_d = s1_valid ? prod_w  : prod_q;
    post_d = s1_valid ? s1_post : post_q;
    raw_d  = s1_valid ? s1_raw  : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
      prod_q <= '0;
      post_q <= '0;
      raw_q  <= '0;
    end else begin
      vld_q  <= s1_valid;
      pass_q <= pass_d;
      prod_q <= prod_d;
      post_q <= post_d;
      raw_q  <= raw_d;
    end
  end

  assign s2_valid = vld_q;
  assign s2_pass  = pass_q;
  assign s2_prod  = prod_q;
  assign s2_post  = post_q;
  assign s2_raw   = raw_q;

endmodule

// File: rtl/pix_csc_sum_stage.sv
module pix_csc_sum_stage #(
  parameter int N_CH   = 3,
  parameter int PIX_W  = 8,
  parameter int OFF_W  = 9,
  parameter int FRAC_W = 8,
  parameter int PROD_W = 21,
  parameter int ACC_W  = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               s2_valid,
  input  logic                               s2_pass,
  input  logic [N_CH*N_CH-1:0][PROD_W-1:0]   s2_prod,
  input  logic [N_CH-1:0][OFF_W-1:0]         s2_post,
  input  logic [N_CH-1:0][PIX_W-1:0]         s2_raw,
  output logic                               o_valid,
  output logic [N_CH-1:0][PIX_W-1:0]         o_pix
);

  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX  = ACC_W'((1 << PIX_W) - 1);

  logic                       vld_q;
  logic [N_CH-1:0][PIX_W-1:0] pix_q, pix_d;
  logic [N_CH-1:0][PIX_W-1:0] sat_w;

  for (genvar r = 0; r < N_CH; r++) begin : g_out
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] scaled_s;
    always_comb begin
      acc_s = (ACC_W'($signed(s2_post[r])) <<< FRAC_W) + HALF_LSB;
      for (int c = 0; c < N_CH; c++) begin
        acc_s = acc_s + ACC_W'($signed(s2_prod[r*N_CH+c]));
      end
      scaled_s = acc_s >>> FRAC_W;
      if (scaled_s < 0) begin
        sat_w[r] = '0;
      end else if (scaled_s > PIX_MAX) begin
        sat_w[r] = '1;
      end else begin
        sat_w[r] = scaled_s[PIX_W-1:0];
      end
    end
  end

  always_comb begin
    pix_d = pix_q;
    if (s2_valid) begin
      pix_d = s2_pass ? s2_raw : sat_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else begin
      vld_q <= s2_valid;
      pix_q <= pix_d;
    end
  end

  assign o_valid = vld_q;
  assign o_pix   = pix_q;

endmodule

// File: rtl/pix_csc.sv
module pix_csc
  import pix_csc_pkg::*;
#(
  parameter int PIX_W  = CSC_PIX_W,
  parameter int COEF_W = CSC_COEF_W,
  parameter int OFF_W  = CSC_OFF_W,
  parameter int FRAC_W = CSC_FRAC_W,
  parameter int ADDR_W = CSC_ADDR_W,
  parameter int DATA_W = CSC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        mode,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in_a,
  input  logic [PIX_W-1:0]  pix_in_b,
  input  logic [PIX_W-1:0]  pix_in_c,
  output logic              out_valid,
  output logic [PIX_W-1:0]  pix_out_a,
  output logic [PIX_W-1:0]  pix_out_b,
  output logic [PIX_W-1:0]  pix_out_c
);

  localparam int N_CH   = CSC_N_CH;
  localparam int N_MAT  = N_CH * N_CH;
  localparam int V_W    = PIX_W + 2;
  localparam int PROD_W = COEF_W + V_W;
  localparam int ACC_W  = PROD_W + $clog2(N_CH + 2);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [N_CH-1:0][PIX_W-1:0]  pix_in_w;
  logic [N_MAT-1:0][COEF_W-1:0] act_m;
  logic [N_CH-1:0][OFF_W-1:0]  act_d, eff_d;
  logic                        cfg_pend;
  logic                        commit_ok;

  logic                        s1_valid, s1_pass;
  logic [N_CH-1:0][V_W-1:0]    s1_opnd;
  logic [N_CH-1:0][OFF_W-1:0]  s1_post;
  logic [N_CH-1:0][PIX_W-1:0]  s1_raw;

  logic                        s2_valid, s2_pass;
  logic [N_MAT-1:0][PROD_W-1:0] s2_prod;
  logic [N_CH-1:0][OFF_W-1:0]  s2_post;
  logic [N_CH-1:0][PIX_W-1:0]  s2_raw;

  logic [N_CH-1:0][PIX_W-1:0]  out_w;

  assign pix_in_w  = {pix_in_c, pix_in_b, pix_in_a};
  assign commit_ok = !s1_valid && !s2_valid && (!pix_valid || frame_start);

  pix_csc_coef_bank #(
    .N_CH(N_CH), .COEF_W(COEF_W), .OFF_W(OFF_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .commit_ok(commit_ok),
    .pending  (cfg_pend),
    .act_m    (act_m),
    .act_d    (act_d),
    .eff_d    (eff_d)
  );

  pix_csc_offset_stage #(
    .N_CH(N_CH), .PIX_W(PIX_W), .OFF_W(OFF_W), .V_W(V_W)
  ) u_s1 (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .in_valid(pix_valid),
    .in_mode (mode),
    .in_pix  (pix_in_w),
    .off_d   (eff_d),
    .s1_valid(s1_valid),
    .s1_pass (s1_pass),
    .s1_opnd (s1_opnd),
    .s1_post (s1_post),
    .s1_raw  (s1_raw)
  );

  pix_csc_mult_stage #(
    .N_CH(N_CH), .PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W),
    .V_W(V_W), .PROD_W(PROD_W)
  ) u_s2 (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .s1_valid(s1_valid),
    .s1_pass (s1_pass),
    .s1_opnd (s1_opnd),
    .s1_post (s1_post),
    .s1_raw  (s1_raw),
    .coef    (act_m),
    .s2_valid(s2_valid),
    .s2_pass (s2_pass),
    .s2_prod (s2_prod),
    .s2_post (s2_post),
    .s2_raw  (s2_raw)
  );

  pix_csc_sum_stage #(
    .N_CH(N_CH), .PIX_W(PIX_W), .OFF_W(OFF_W), .FRAC_W(FRAC_W),
    .PROD_W(PROD_W), .ACC_W(ACC_W)
  ) u_s3 (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .s2_valid(s2_valid),
    .s2_pass (s2_pass),
    .s2_prod (s2_prod),
    .s2_post (s2_post),
    .s2_raw  (s2_raw),
    .o_valid (out_valid),
    .o_pix   (out_w)
  );

  assign pix_out_a = out_w[0];
  assign pix_out_b = out_w[1];
  assign pix_out_c = out_w[2];

endmodule

// File: rtl/pix_csc_chk.sv
module pix_csc_chk #(
  parameter int PIX_W = 8,
  parameter int FLD_W = 117
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             pix_valid,
  input logic             cfg_we,
  input logic [1:0]       mode,
  input logic [PIX_W-1:0] pix_in_a,
  input logic [PIX_W-1:0] pix_in_b,
  input logic [PIX_W-1:0] pix_in_c,
  input logic             out_valid,
  input logic [PIX_W-1:0] pix_out_a,
  input logic [PIX_W-1:0] pix_out_b,
  input logic [PIX_W-1:0] pix_out_c,
  input logic             s1_valid,
  input logic             s2_valid,
  input logic             cfg_pend,
  input logic [FLD_W-1:0] act_fields
);

  // Cycles since reset release, saturating at the pipeline depth.
  logic [1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      since_rst_q <= 2'd0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 2'd1;
    end
  end

  // R2: output valid mirrors input valid three edges earlier
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_s_n)
    (since_rst_q == 2'd3) |-> (out_valid == $past(pix_valid, 3)));

  // R3: pass-through modes reproduce the input
  a_r3_pass_exact: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((since_rst_q == 2'd3) && out_valid && $past(pix_valid, 3) &&
     (($past(mode, 3) == 2'b00) || ($past(mode, 3) == 2'b11)))
    |-> ({pix_out_a, pix_out_b, pix_out_c} ==
         $past({pix_in_a, pix_in_b, pix_in_c}, 3)));

  // R9: applied values never change while a pixel is in flight
  a_r9_bank_frozen: assert property (@(posedge clk) disable iff (!rst_s_n)
    (s1_valid || s2_valid) |=> $stable(act_fields));

  // R9: a pending write is applied once the pipeline is idle
  a_r9_idle_apply: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_pend && !s1_valid && !s2_valid && !pix_valid)
    |=> (!cfg_pend || $past(cfg_we)));

  // R10: outputs hold when no result reaches the last stage
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !s2_valid |=> $stable({pix_out_a, pix_out_b, pix_out_c}));

  // R1: nothing comes out right after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_s_n)
    (since_rst_q == 2'd0) |-> !out_valid);

endmodule

bind pix_csc pix_csc_chk #(
  .PIX_W(PIX_W),
  .FLD_W(N_MAT*COEF_W + N_CH*OFF_W)
) chk_i (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .pix_valid (pix_valid),
  .cfg_we    (cfg_we),
  .mode      (mode),
  .pix_in_a  (pix_in_a),
  .pix_in_b  (pix_in_b),
  .pix_in_c  (pix_in_c),
  .out_valid (out_valid),
  .pix_out_a (pix_out_a),
  .pix_out_b (pix_out_b),
  .pix_out_c (pix_out_c),
  .s1_valid  (s1_valid),
  .s2_valid  (s2_valid),
  .cfg_pend  (cfg_pend),
  .act_fields({act_m, act_d})
);

// File: tb/pix_csc_tb_top.sv
module pix_csc_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  mode;
  logic        frame_start;
  logic        pix_valid;
  logic [7:0]  pix_in_a, pix_in_b, pix_in_c;
  logic        out_valid;
  logic [7:0]  pix_out_a, pix_out_b, pix_out_c;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit mon_on = 0;

  // Values the bench believes the datapath is using.
  int cur_m [9];
  int cur_d [3];

  logic [23:0] exp_q [$];
  int          cyc_q [$];
  string       tag_q [$];

  pix_csc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode(mode), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_in_a(pix_in_a), .pix_in_b(pix_in_b),
    .pix_in_c(pix_in_c), .out_valid(out_valid), .pix_out_a(pix_out_a),
    .pix_out_b(pix_out_b), .pix_out_c(pix_out_c)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] model(input logic [1:0] md, input int a,
                                        input int b, input int c);
    int inp [3];
    int acc, res;
    logic [7:0] o [3];
    inp[0] = a; inp[1] = b; inp[2] = c;
    if (md == 2'b00 || md == 2'b11) return {8'(a), 8'(b), 8'(c)};
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int k = 0; k < 3; k++) begin
        if (md == 2'b10) acc += cur_m[r*3+k] * (inp[k] + cur_d[k]);
        else             acc += cur_m[r*3+k] * inp[k];
      end
      if (md == 2'b01) acc += cur_d[r] * 256;
      res = (acc + 128) >>> 8;
      if (res < 0) res = 0;
      if (res > 255) res = 255;
      o[r] = 8'(res);
    end
    return {o[0], o[1], o[2]};
  endfunction

  // Output monitor: every result is compared, with its latency.
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (exp_q.size() == 0) begin
        report(1'b0, "R2", "unexpected output", 32'(1), 32'(0));
      end else begin
        logic [23:0] e;
        int          c0;
        string       t;
        e  = exp_q.pop_front();
        c0 = cyc_q.pop_front();
        t  = tag_q.pop_front();
        report({pix_out_a, pix_out_b, pix_out_c} == e, t, "pixel",
               32'({pix_out_a, pix_out_b, pix_out_c}), 32'(e));
        report((cyc - c0) == 3, "R2", "latency", 32'(cyc - c0), 32'(3));
      end
    end
  end

  function automatic logic [31:0] pack_word(input int w, input int nm [9],
                                            input int nd [3]);
    int f [12];
    for (int k = 0; k < 9; k++) f[k] = nm[k] & 32'h7ff;
    for (int k = 0; k < 3; k++) f[9+k] = nd[k] & 32'h1ff;
    return 32'((f[2*w] << 16) | f[2*w+1]);
  endfunction

  task automatic go_idle();
    pix_valid   = 1'b0;
    frame_start = 1'b0;
    cfg_we      = 1'b0;
  endtask

  task automatic put(input logic [1:0] md, input int a, input int b,
                     input int c, input bit fs, input string tag);
    pix_valid   = 1'b1;
    frame_start = fs;
    mode        = md;
    pix_in_a    = 8'(a);
    pix_in_b    = 8'(b);
    pix_in_c    = 8'(c);
    exp_q.push_back(model(md, a, b, c));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    go_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_bank(input int nm [9], input int nd [3]);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      pix_valid = 1'b0;
      cfg_we    = 1'b1;
      cfg_addr  = 3'(w);
      cfg_wdata = pack_word(w, nm, nd);
    end
    @(negedge clk);
    go_idle();
    @(negedge clk);
    @(negedge clk);
    cur_m = nm;
    cur_d = nd;
  endtask

  int bt601_m [9] = '{298, 0, 409, 298, -100, -208, 298, 516, 0};
  int bt601_d [3] = '{-16, -128, -128};
  int fwd_m   [9] = '{65, 129, 25, -37, -74, 112, 112, -94, -18};
  int fwd_d   [3] = '{16, 128, 128};
  int half_m  [9] = '{128, 0, 0, 0, 128, 0, 0, 0, 128};
  int zero_d  [3] = '{0, 0, 0};
  int unit_m  [9] = '{256, 0, 0, 0, 256, 0, 0, 0, 256};

  task automatic t_reset();
    report(!out_valid && pix_out_a == 0 && pix_out_b == 0 && pix_out_c == 0,
           "R1", "reset state", 32'({out_valid, pix_out_a, pix_out_b, pix_out_c}),
           32'(0));
  endtask

  task automatic t_bypass();
    @(negedge clk); put(2'b00, 12, 200, 77, 0, "R3");
    @(negedge clk); put(2'b00, 255, 0, 128, 0, "R3");
    @(negedge clk); put(2'b11, 1, 2, 3, 0, "R3");
    @(negedge clk); put(2'b11, 250, 17, 99, 0, "R3");
    drain();
  endtask

  task automatic t_inverse();
    load_bank(bt601_m, bt601_d);
    @(negedge clk); put(2'b10, 16, 128, 128, 0, "R4");
    @(negedge clk); put(2'b10, 235, 128, 128, 0, "R4");
    @(negedge clk); put(2'b10, 81, 90, 240, 0, "R4");
    @(negedge clk); put(2'b10, 145, 54, 34, 0, "R4");
    drain();
  endtask

  task automatic t_clamp();
    @(negedge clk); put(2'b10, 255, 255, 255, 0, "R7");
    @(negedge clk); put(2'b10, 0, 0, 0, 0, "R7");
    @(negedge clk); put(2'b10, 0, 255, 0, 0, "R7");
    drain();
  endtask

  task automatic t_forward();
    load_bank(fwd_m, fwd_d);
    @(negedge clk); put(2'b01, 0, 0, 0, 0, "R5");
    @(negedge clk); put(2'b01, 255, 255, 255, 0, "R5");
    @(negedge clk); put(2'b01, 255, 0, 0, 0, "R5");
    @(negedge clk); put(2'b01, 30, 160, 90, 0, "R5");
    drain();
  endtask

  task automatic t_round();
    int neg_d [3] = '{-1, 0, 0};
    load_bank(half_m, zero_d);
    @(negedge clk); put(2'b01, 1, 3, 5, 0, "R6");
    @(negedge clk); put(2'b01, 2, 4, 255, 0, "R6");
    drain();
    load_bank(half_m, neg_d);
    @(negedge clk); put(2'b10, 0, 7, 9, 0, "R6");
    drain();
  endtask

  task automatic t_field_map();
    // R8: writes to addresses 6 and 7 must not disturb the loaded fields.
    load_bank(unit_m, fwd_d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'h07ff_07ff;
    @(negedge clk);
    cfg_addr = 3'd7; cfg_wdata = 32'h07ff_07ff;
    @(negedge clk);
    go_idle();
    @(negedge clk);
    @(negedge clk); put(2'b01, 10, 20, 30, 0, "R8");
    @(negedge clk); put(2'b10, 10, 20, 30, 0, "R8");
    drain();
  endtask

  task automatic t_write_while_streaming();
    logic [31:0] w [6];
    load_bank(bt601_m, bt601_d);
    for (int k = 0; k < 6; k++) w[k] = pack_word(k, unit_m, zero_d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      put(2'b10, 20 + i * 25, 100 + i, 200 - i * 3, 0, "R9");
      if (i >= 2) begin
        cfg_we = 1'b1; cfg_addr = 3'(i - 2); cfg_wdata = w[i-2];
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk); go_idle();
    @(negedge clk);
    // Resume after a drained gap, no frame marker: old values remain.
    @(negedge clk); put(2'b10, 60, 110, 150, 0, "R9");
    @(negedge clk); put(2'b10, 70, 120, 160, 0, "R9");
    @(negedge clk); go_idle();
    @(negedge clk);
    // Frame marker on a drained pipeline: this pixel already uses new values.
    @(negedge clk);
    cur_m = unit_m;
    cur_d = zero_d;
    put(2'b10, 60, 110, 150, 1, "R9");
    @(negedge clk); put(2'b10, 70, 120, 160, 0, "R9");
    drain();
  endtask

  task automatic t_hold();
    logic [23:0] snap;
    @(negedge clk); put(2'b01, 40, 50, 60, 0, "R10");
    drain();
    snap = {pix_out_a, pix_out_b, pix_out_c};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pix_in_a = 8'(i * 61); pix_in_b = 8'(i * 17); pix_in_c = 8'(i * 5);
      mode = 2'(i);
    end
    @(negedge clk);
    @(negedge clk);
    report({pix_out_a, pix_out_b, pix_out_c} == snap, "R10", "hold",
           32'({pix_out_a, pix_out_b, pix_out_c}), 32'(snap));
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; mode = 2'b00;
    pix_in_a = '0; pix_in_b = '0; pix_in_c = '0;
    go_idle();
    for (int k = 0; k < 9; k++) cur_m[k] = 0;
    for (int k = 0; k < 3; k++) cur_d[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    mon_on = 1'b1;
    t_bypass();
    t_inverse();
    t_clamp();
    t_forward();
    t_round();
    t_field_map();
    t_write_while_streaming();
    t_hold();
    repeat (3) @(negedge clk);
    report(exp_q.size() == 0, "R2", "missing outputs", 32'(exp_q.size()), 32'(0));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule